// File: doc/BRIEF.md
# Multi-Hart Self-Test Report Checker

This block watches the store traffic of a data-bus write port and picks out the stores that fall inside a window set aside for self-test reports from several processor harts. Each report is a 32-bit word; the hart that wrote it and the kind of report are both encoded in the store address, and the word itself carries the reported value. The checker compares every report against what a correct multi-hart test program must produce. Barrier arrivals are counted per barrier ID, so a hart that leaves a barrier before every hart has entered it is caught. Per-hart completion is tracked, and a final verdict is raised.

A report may arrive as one full-word store or as several narrower stores. Every byte written inside the window updates its lane of a holding word. The report is evaluated only when the store that writes byte lane 3 arrives. Each evaluated report yields a one-cycle verdict strobe.

The verdict is held in a three-state machine. RUN is the state after reset. RUN goes to FAIL when any check fails, and goes to PASS once every hart has reported a clean end. PASS goes to FAIL if a later report fails a check. FAIL is absorbing until reset. The first failure's hart, code and data are captured and kept.

Top module: `hart_report_checker`

## Requirements
- R1: A store is a report only when word-address bits [31:28] equal 0xF and bits [27:24] equal 0x8. Any other store produces no verdict and leaves pass, err and the holding word unchanged.
- R2: Each in-window store writes its enabled byte lanes into a holding word; lanes not enabled keep their earlier value. A report is evaluated (exactly one verdict) only for a store with byte enable 3 set, using the merged word.
- R3: Address bits [23:16] give the hart index and bits [15:0] the code. Code 0x00 passes only when the data equals the hart index.
- R4: Code 0x04 passes only when the data equals the configured hart count NUM_HARTS.
- R5: Code 0x08 passes only when the data is 0 and that hart has not already ended cleanly; a passing end marks the hart done.
- R6: pass rises one cycle after the last hart is marked done, provided no check has failed.
- R7: Code 0x0C (barrier entry, data = barrier ID) passes only when that ID's arrival count is below NUM_HARTS, and then increments the count. Counts are zero after reset.
- R8: Code 0x10 (barrier exit, data = barrier ID) passes only when that ID's count equals NUM_HARTS.
- R9: A barrier ID of NUM_BARRIERS or more, a hart index of NUM_HARTS or more, or any code other than 0x00, 0x04, 0x08, 0x0C and 0x10 fails the check.
- R10: The first failed check sets err, which stays set until reset. It captures err_hart, err_code and err_data, which later failures do not change, and pass is then held low.
- R11: chk_valid pulses for one cycle two clock edges after the completing store is sampled, with chk_ok = 1 for a passing report and 0 for a failing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store present on the bus this cycle |
| wr_waddr | input | 30 | Store word address (byte address bits 31..2) |
| wr_be | input | 4 | Byte-lane enables of the store |
| wr_data | input | 32 | Store data |
| chk_valid | output | 1 | One-cycle strobe: a report was evaluated |
| chk_ok | output | 1 | The evaluated report passed its check |
| pass | output | 1 | All harts ended cleanly with no failure |
| err | output | 1 | Sticky failure flag |
| err_hart | output | 8 | Hart index of the first failure |
| err_code | output | 16 | Report code of the first failure |
| err_data | output | 32 | Report data of the first failure |

## Verification
The hardest condition to reach from the ports is a barrier counter at its limit: exit is legal only with exactly NUM_HARTS arrivals, and a further entry must be rejected. The stimulus drives entries from every hart to one ID, then a surplus entry. In a separate run, an exit follows only a partial set of arrivals. Two more cases are reached deliberately. In one, all harts end after an earlier failure, to show that pass stays blocked. In the other, a word is assembled from split byte stores whose untouched lanes still hold stale bytes, and err_data exposes the merged value.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

    localparam int LANES = 4;

    // window selection on word-address nibbles
    localparam logic [3:0] WIN_TOP = 4'hF;
    localparam logic [3:0] WIN_SUB = 4'h8;

    // report codes
    localparam logic [15:0] CODE_TID    = 16'h0000;
    localparam logic [15:0] CODE_TCNT   = 16'h0004;
    localparam logic [15:0] CODE_END    = 16'h0008;
    localparam logic [15:0] CODE_BENTER = 16'h000C;
    localparam logic [15:0] CODE_BEXIT  = 16'h0010;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PASS = 2'd1,
        ST_FAIL = 2'd2
    } chk_state_e;

    typedef struct packed {
        logic [7:0]  hart;
        logic [15:0] code;
        logic [31:0] data;
    } report_t;

endpackage

// File: rtl/hrc_lane_merge.sv
module hrc_lane_merge
    import hrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:2] wr_waddr,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic        rpt_valid,
    output report_t     rpt
);

    logic        in_window;
    logic        win_wr;
    logic [31:0] hold_q;
    logic [31:0] merged;

    assign in_window = (wr_waddr[31:28] == WIN_TOP) && (wr_waddr[27:24] == WIN_SUB);
    assign win_wr    = wr_valid && in_window;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : hold_q[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            rpt_valid <= 1'b0;
            rpt       <= '0;
        end else begin
            rpt_valid <= win_wr && wr_be[LANES-1];
            if (win_wr) begin
                hold_q <= merged;
            end
            if (win_wr && wr_be[LANES-1]) begin
                rpt.hart <= wr_waddr[23:16];
                rpt.code <= {wr_waddr[15:2], 2'b00};
                rpt.data <= merged;
            end
        end
    end

    // R2: a report only follows a store that wrote the top lane
    p_act_needs_lane3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> $past(wr_valid && wr_be[LANES-1]));

endmodule

// File: rtl/hrc_barrier_table.sv
module hrc_barrier_table #(
    parameter  int NUM_HARTS    = 4,
    parameter  int NUM_BARRIERS = 16,
    localparam int CW           = $clog2(NUM_HARTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   rd_id,
    input  logic          inc_en,
    output logic          id_ok,
    output logic [CW-1:0] rd_cnt
);

    localparam logic [CW-1:0] CNT_FULL = CW'(NUM_HARTS);

    logic [CW-1:0] cnt_q [NUM_BARRIERS];

    assign id_ok = rd_id < 32'(NUM_BARRIERS);

    always_comb begin
        rd_cnt = '0;
        for (int i = 0; i < NUM_BARRIERS; i++) begin
            if (rd_id == 32'(i)) begin
                rd_cnt = cnt_q[i];
            end
        end
    end

    for (genvar i = 0; i < NUM_BARRIERS; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
            end else if (inc_en && (rd_id == 32'(i))) begin
                cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end

        // R7: no barrier ever records more arrivals than there are harts
        p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[i] <= CNT_FULL);
    end

endmodule

// File: rtl/hrc_done_track.sv
module hrc_done_track #(
    parameter  int NUM_HARTS = 4,
    localparam int HW        = $clog2(NUM_HARTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [HW-1:0] idx,
    output logic          is_done,
    output logic          all_done
);

    logic [NUM_HARTS-1:0] done_q;

    assign is_done  = done_q[idx];
    assign all_done = &done_q;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_done
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q[h] <= 1'b0;
            end else if (set_en && (idx == HW'(h))) begin
                done_q[h] <= 1'b1;
            end
        end

        // R5: a completed hart never becomes un-completed
        p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            done_q[h] |=> done_q[h]);
    end

endmodule

// File: rtl/hart_report_checker.sv
module hart_report_checker
    import hrc_pkg::*;
#(
    parameter int NUM_HARTS    = 4,
    parameter int NUM_BARRIERS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:2] wr_waddr,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic        chk_valid,
    output logic        chk_ok,
    output logic        pass,
    output logic        err,
    output logic [7:0]  err_hart,
    output logic [15:0] err_code,
    output logic [31:0] err_data
);

    localparam int HW = $clog2(NUM_HARTS);
    localparam int CW = $clog2(NUM_HARTS + 1);
    localparam logic [7:0]    HART_LIM = 8'(NUM_HARTS);
    localparam logic [31:0]   HART_CNT = 32'(NUM_HARTS);
    localparam logic [CW-1:0] CNT_FULL = CW'(NUM_HARTS);

    logic          rpt_valid;
    report_t       rpt;
    logic          id_ok;
    logic [CW-1:0] bar_cnt;
    logic          hart_done;
    logic          all_done;
    logic          hart_ok;
    logic          rpt_ok;
    logic          fail_now;
    logic          done_set;
    logic          bar_inc;
    chk_state_e    state_q, state_d;

    hrc_lane_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_waddr  (wr_waddr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rpt_valid (rpt_valid),
        .rpt       (rpt)
    );

    hrc_barrier_table #(
        .NUM_HARTS    (NUM_HARTS),
        .NUM_BARRIERS (NUM_BARRIERS)
    ) u_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_id  (rpt.data),
        .inc_en (bar_inc),
        .id_ok  (id_ok),
        .rd_cnt (bar_cnt)
    );

    hrc_done_track #(
        .NUM_HARTS (NUM_HARTS)
    ) u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (done_set),
        .idx      (rpt.hart[HW-1:0]),
        .is_done  (hart_done),
        .all_done (all_done)
    );

    // report evaluation
    assign hart_ok = rpt.hart < HART_LIM;

    always_comb begin
        unique case (rpt.code)
            CODE_TID:    rpt_ok = hart_ok && (rpt.data == {24'd0, rpt.hart});
            CODE_TCNT:   rpt_ok = hart_ok && (rpt.data == HART_CNT);
            CODE_END:    rpt_ok = hart_ok && (rpt.data == 32'd0) && !hart_done;
            CODE_BENTER: rpt_ok = hart_ok && id_ok && (bar_cnt < CNT_FULL);
            CODE_BEXIT:  rpt_ok = hart_ok && id_ok && (bar_cnt == CNT_FULL);
            default:     rpt_ok = 1'b0;
        endcase
    end

    assign fail_now = rpt_valid && !rpt_ok;
    assign done_set = rpt_valid && rpt_ok && (rpt.code == CODE_END);
    assign bar_inc  = rpt_valid && rpt_ok && (rpt.code == CODE_BENTER);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fail_now) begin
                    state_d = ST_FAIL;
                end else if (all_done) begin
                    state_d = ST_PASS;
                end
            end
            ST_PASS: begin
                if (fail_now) begin
                    state_d = ST_FAIL;
                end
            end
            ST_FAIL: state_d = ST_FAIL;
            default: state_d = ST_FAIL;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_ok    <= 1'b0;
            err_hart  <= '0;
            err_code  <= '0;
            err_data  <= '0;
        end else begin
            chk_valid <= rpt_valid;
            chk_ok    <= rpt_valid && rpt_ok;
            if (fail_now && (state_q != ST_FAIL)) begin
                err_hart <= rpt.hart;
                err_code <= rpt.code;
                err_data <= rpt.data;
            end
        end
    end

    assign pass = (state_q == ST_PASS);
    assign err  = (state_q == ST_FAIL);

    // R6: pass only with every hart completed
    p_pass_all_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> all_done);

    // R10: failure is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10: pass and err are never both raised
    p_pass_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && err));

    // R10: captured failure fields are frozen
    p_err_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> ($stable(err_hart) && $stable(err_code) && $stable(err_data)));

    // R11: a verdict only follows an assembled report
    p_verdict_after_report_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> $past(rpt_valid));

endmodule

// File: tb/hart_report_checker_test.sv
`timescale 1ns/1ps
module hart_report_checker_test;

    localparam int NH = 4;
    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:2] wr_waddr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        chk_valid, chk_ok, pass, err;
    logic [7:0]  err_hart;
    logic [15:0] err_code;
    logic [31:0] err_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit    ok_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    hart_report_checker #(.NUM_HARTS(NH), .NUM_BARRIERS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_waddr(wr_waddr),
        .wr_be(wr_be), .wr_data(wr_data), .chk_valid(chk_valid), .chk_ok(chk_ok),
        .pass(pass), .err(err), .err_hart(err_hart), .err_code(err_code),
        .err_data(err_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected verdicts as the design produces them
    always @(negedge clk) begin
        if (rst_n && chk_valid) begin
            if (ok_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected verdict actual=%0d expected=none", chk_ok);
            end else begin
                bit    e;
                string t;
                e = ok_q.pop_front();
                t = tag_q.pop_front();
                check(t, {31'd0, chk_ok}, {31'd0, e});
            end
        end
    end

    function automatic logic [31:2] win_addr(input logic [7:0] hart, input logic [15:0] code);
        return {4'hF, 4'h8, hart, code[15:2]};
    endfunction

    task automatic drive(input logic [31:2] a, input logic [3:0] be, input logic [31:0] d);
        wr_valid = 1'b1;
        wr_waddr = a;
        wr_be    = be;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rep(input logic [7:0] hart, input logic [15:0] code,
                       input logic [31:0] data, input bit ok, input string tag);
        ok_q.push_back(ok);
        tag_q.push_back(tag);
        drive(win_addr(hart, code), 4'hF, data);
    endtask

    task automatic settle(input string tag);
        repeat (5) @(negedge clk);
        check({tag, " pending verdicts"}, ok_q.size(), 0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        ok_q.delete();
        tag_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R10 reset err", {31'd0, err}, 0);
        check("R6 reset pass", {31'd0, pass}, 0);
        check("R11 reset chk_valid", {31'd0, chk_valid}, 0);

        // clean run
        for (int h = 0; h < NH; h++) rep(8'(h), 16'h0000, 32'(h), 1, "R3 tid");
        for (int h = 0; h < NH; h++) rep(8'(h), 16'h0004, 32'(NH), 1, "R4 tcnt");
        for (int h = 0; h < NH; h++) rep(8'(h), 16'h000C, 32'd1, 1, "R7 enter");
        for (int h = 0; h < NH; h++) rep(8'(h), 16'h0010, 32'd1, 1, "R8 exit");
        // R2: count assembled from two partial stores, one verdict
        drive(win_addr(8'd2, 16'h0004), 4'b0001, 32'h0000_0004);
        ok_q.push_back(1);
        tag_q.push_back("R2 merged tcnt");
        drive(win_addr(8'd2, 16'h0004), 4'b1110, 32'h0000_0000);
        for (int h = 0; h < NH - 1; h++) rep(8'(h), 16'h0008, 32'd0, 1, "R5 end");
        settle("R5");
        check("R6 pass before last end", {31'd0, pass}, 0);
        rep(8'd3, 16'h0008, 32'd0, 1, "R5 last end");
        settle("R6");
        check("R6 pass after all ends", {31'd0, pass}, 1);
        check("R6 err after all ends", {31'd0, err}, 0);
        // R1: stores outside the window are ignored
        drive({4'hE, 4'h8, 8'd0, 14'd0}, 4'hF, 32'h55);
        drive({4'hF, 4'h9, 8'd1, 14'd0}, 4'hF, 32'h66);
        settle("R1");
        check("R1 pass kept", {31'd0, pass}, 1);
        check("R1 err kept", {31'd0, err}, 0);

        // exit before all arrived, then a second failure
        do_reset();
        rep(8'd0, 16'h000C, 32'd3, 1, "R7 enter");
        rep(8'd1, 16'h000C, 32'd3, 1, "R7 enter");
        rep(8'd1, 16'h0010, 32'd3, 0, "R8 early exit");
        rep(8'd2, 16'h0014, 32'd9, 0, "R9 unknown code");
        settle("R8");
        check("R10 err set", {31'd0, err}, 1);
        check("R10 err_hart", {24'd0, err_hart}, 1);
        check("R10 err_code", {16'd0, err_code}, 32'h10);
        check("R10 err_data first", err_data, 3);

        // surplus barrier entry
        do_reset();
        for (int h = 0; h < NH; h++) rep(8'(h), 16'h000C, 32'd7, 1, "R7 enter");
        rep(8'd0, 16'h000C, 32'd7, 0, "R7 surplus enter");
        settle("R7");
        check("R7 err_code", {16'd0, err_code}, 32'h0C);

        // single-report failures
        do_reset(); rep(8'd2, 16'h0000, 32'd1, 0, "R3 bad tid"); settle("R3");
        check("R3 err_hart", {24'd0, err_hart}, 2);
        do_reset(); rep(8'd0, 16'h0004, 32'd3, 0, "R4 bad tcnt"); settle("R4");
        check("R4 err_data", err_data, 3);
        do_reset(); rep(8'd1, 16'h0008, 32'd1, 0, "R5 nonzero end"); settle("R5");
        do_reset();
        rep(8'd1, 16'h0008, 32'd0, 1, "R5 end");
        rep(8'd1, 16'h0008, 32'd0, 0, "R5 repeated end");
        settle("R5");
        do_reset(); rep(8'd0, 16'h000C, 32'(NB), 0, "R9 id out of table"); settle("R9");
        do_reset(); rep(8'(NH + 1), 16'h0000, 32'(NH + 1), 0, "R9 hart out of range"); settle("R9");

        // R2: stale lanes carried into the merged word
        do_reset();
        rep(8'd0, 16'h0000, 32'd0, 1, "R3 tid");
        drive(win_addr(8'd0, 16'h0000), 4'b0111, 32'h00FF_FFFF);
        ok_q.push_back(0);
        tag_q.push_back("R2 stale merge");
        drive(win_addr(8'd0, 16'h0000), 4'b1000, 32'h0000_0000);
        settle("R2");
        check("R2 merged err_data", err_data, 32'h00FF_FFFF);

        // failure then all ends: pass stays blocked
        do_reset();
        rep(8'd0, 16'h0000, 32'd5, 0, "R10 bad tid");
        for (int h = 0; h < NH; h++) rep(8'(h), 16'h0008, 32'd0, 1, "R5 end");
        settle("R10");
        check("R10 pass blocked", {31'd0, pass}, 0);
        check("R10 err held", {31'd0, err}, 1);
        check("R10 err_code held", {16'd0, err_code}, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule